// File: doc/BRIEF.md
# Rotating Register File Renamer

This block is a 128-entry, 64-bit general-purpose register file built for software-pipelined loops. Every register specifier that reaches it is first translated to a physical entry. The translation adds a run-time rotating base, so the same instruction reaches a different physical register on each loop iteration. A loop can then be expressed once instead of being unrolled, which keeps code size down.

The lower 32 specifiers form a static region and map to themselves. The upper 96 specifiers form a rotating region. There, the physical entry is `32 + ((spec - 32 + base) mod 96)`. Each pulse of the rotate strobe steps the base down by one, modulo 96. A value written to specifier r in one iteration is therefore read as specifier r+1 in the next. A clear strobe returns the base to zero.

The block has two combinational read ports and one write port. The write is committed at the clock edge. Loop-branch decode, predicates and issue are not part of the block; the rotate strobe stands in for them.

Top module: `rrf_rotating_regfile`

## Requirements
- R1: While reset is held and after it is released, every specifier reads as zero and the rotating base is zero, so specifier s reaches physical entry s.
- R2: Specifier 0 always reads as zero on both read ports, and a write to specifier 0 has no effect.
- R3: Specifiers 1 to 31 are never remapped: a value written to one of them reads back from the same specifier regardless of how many rotations occur.
- R4: With the base at zero, a value written to a specifier in 32..127 reads back from that same specifier.
- R5: After one rotate pulse, a value written to specifier r (32 <= r <= 126) before the pulse is read from specifier r+1.
- R6: The rotating region wraps: after one rotate pulse, a value written to specifier 127 before the pulse is read from specifier 32.
- R7: When a write and a rotate pulse occur in the same cycle, the write is placed using the base from before the pulse. The new base applies from the next cycle.
- R8: A clear pulse sets the base to zero, so afterwards every specifier reaches the physical entry of the same number.
- R9: When clear and rotate are asserted in the same cycle, clear wins and the base becomes zero.
- R10: After 96 rotate pulses the base returns to its starting value. With no rotate and no clear, the base holds.
- R11: The two read ports are independent: each returns the entry selected by its own specifier, including when both name the same register.
- R12: A write is visible on the read ports from the cycle after its clock edge. A read of the register being written in the same cycle returns the old content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; clears the base and all entries |
| rot_i | input | 1 | Rotate strobe: steps the base down by one, modulo 96 |
| clr_i | input | 1 | Clear strobe: base returns to zero; has priority over rotate |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 7 | Write specifier |
| wr_data_i | input | 64 | Write data |
| rd_a_idx_i | input | 7 | Read port A specifier |
| rd_a_data_o | output | 64 | Read port A data (combinational) |
| rd_b_idx_i | input | 7 | Read port B specifier |
| rd_b_data_o | output | 64 | Read port B data (combinational) |

## Verification
The remapping is driven with writes to static, mid-region and top-of-region specifiers. These are read back at the same specifier with the base at zero, and at the shifted specifier after a rotate. This separates an identity mapping from a correct shift and from a broken wrap at the top of the region. Rows that combine a write with a rotate in one cycle show whether the old or the new base places the write. Rows that combine clear with rotate show which of the two takes priority. A long run of 95 and then 96 rotations shows whether the modulo arithmetic returns the base to its start. A final reset and writes to specifier 0 check the hard-wired zero and the cleared state.

// File: rtl/rrf_pkg.sv
package rrf_pkg;
    localparam int unsigned RRF_NUM_REGS   = 128;
    localparam int unsigned RRF_NUM_STATIC = 32;
    localparam int unsigned RRF_DATA_W     = 64;
    localparam int unsigned RRF_IDX_W      = $clog2(RRF_NUM_REGS);
    localparam int unsigned RRF_ROT_N      = RRF_NUM_REGS - RRF_NUM_STATIC;
    localparam int unsigned RRF_BASE_W     = $clog2(RRF_ROT_N);
    localparam int unsigned RRF_N_MAPS     = 3;  // write, read A, read B
endpackage

// File: rtl/rrf_base_ctrl.sv
module rrf_base_ctrl #(
    parameter int unsigned ROT_N  = rrf_pkg::RRF_ROT_N,
    parameter int unsigned BASE_W = rrf_pkg::RRF_BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rot_i,
    input  logic              clr_i,
    output logic [BASE_W-1:0] base_o
);
    typedef struct packed {
        logic [BASE_W-1:0] base;
    } base_state_t;

    base_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.base = '0;
        end else if (rot_i) begin
            if (st_q.base == '0) st_d.base = BASE_W'(ROT_N - 1);
            else                 st_d.base = st_q.base - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o = st_q.base;

    assert_base_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        base_o < BASE_W'(ROT_N));
    assert_base_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_i && !clr_i) |=> $stable(base_o));
    assert_clr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (base_o == '0));
    assert_clr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && rot_i) |=> (base_o == '0));
    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_i && !clr_i && base_o == '0) |=> (base_o == BASE_W'(ROT_N - 1)));
endmodule

// File: rtl/rrf_remap.sv
module rrf_remap #(
    parameter int unsigned NUM_REGS   = rrf_pkg::RRF_NUM_REGS,
    parameter int unsigned NUM_STATIC = rrf_pkg::RRF_NUM_STATIC,
    parameter int unsigned IDX_W      = rrf_pkg::RRF_IDX_W,
    parameter int unsigned BASE_W     = rrf_pkg::RRF_BASE_W
) (
    input  logic [IDX_W-1:0]  spec_i,
    input  logic [BASE_W-1:0] base_i,
    output logic [IDX_W-1:0]  phys_o
);
    localparam int unsigned ROT_N = NUM_REGS - NUM_STATIC;
    localparam int unsigned SUM_W = IDX_W + 1;

    logic [SUM_W-1:0] off_w;
    logic [SUM_W-1:0] sum_w;

    always_comb begin
        off_w  = {1'b0, spec_i} - SUM_W'(NUM_STATIC);
        sum_w  = off_w + SUM_W'(base_i);
        if (sum_w >= SUM_W'(ROT_N)) sum_w = sum_w - SUM_W'(ROT_N);
        if (spec_i < IDX_W'(NUM_STATIC)) phys_o = spec_i;
        else                             phys_o = IDX_W'(sum_w + SUM_W'(NUM_STATIC));
    end
endmodule

// File: rtl/rrf_storage.sv
module rrf_storage #(
    parameter int unsigned NUM_REGS = rrf_pkg::RRF_NUM_REGS,
    parameter int unsigned DATA_W   = rrf_pkg::RRF_DATA_W,
    parameter int unsigned IDX_W    = rrf_pkg::RRF_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  wr_phys_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_a_phys_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [IDX_W-1:0]  rd_b_phys_i,
    output logic [DATA_W-1:0] rd_b_data_o
);
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        regs_d = regs_q;
        if (we_i && wr_phys_i != '0) regs_d[wr_phys_i] = wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NUM_REGS); i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_a_data_o = (rd_a_phys_i == '0) ? '0 : regs_q[rd_a_phys_i];
    assign rd_b_data_o = (rd_b_phys_i == '0) ? '0 : regs_q[rd_b_phys_i];

    assert_zero_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0] == '0);
    assert_write_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wr_phys_i != '0) |=> (regs_q[$past(wr_phys_i)] == $past(wr_data_i)));
endmodule

// File: rtl/rrf_rotating_regfile.sv
module rrf_rotating_regfile #(
    parameter int unsigned NUM_REGS   = rrf_pkg::RRF_NUM_REGS,
    parameter int unsigned NUM_STATIC = rrf_pkg::RRF_NUM_STATIC,
    parameter int unsigned DATA_W     = rrf_pkg::RRF_DATA_W,
    parameter int unsigned IDX_W      = $clog2(NUM_REGS),
    parameter int unsigned BASE_W     = $clog2(NUM_REGS - NUM_STATIC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rot_i,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [IDX_W-1:0]  rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o
);
    localparam int unsigned ROT_N  = NUM_REGS - NUM_STATIC;
    localparam int unsigned N_MAPS = rrf_pkg::RRF_N_MAPS;

    logic [BASE_W-1:0] base_w;
    logic [IDX_W-1:0]  spec_w [N_MAPS];
    logic [IDX_W-1:0]  phys_w [N_MAPS];

    assign spec_w[0] = wr_idx_i;
    assign spec_w[1] = rd_a_idx_i;
    assign spec_w[2] = rd_b_idx_i;

    rrf_base_ctrl #(.ROT_N(ROT_N), .BASE_W(BASE_W)) base_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rot_i  (rot_i),
        .clr_i  (clr_i),
        .base_o (base_w)
    );

    for (genvar g = 0; g < int'(N_MAPS); g++) begin : g_map
        rrf_remap #(
            .NUM_REGS(NUM_REGS), .NUM_STATIC(NUM_STATIC),
            .IDX_W(IDX_W), .BASE_W(BASE_W)
        ) map_i (
            .spec_i (spec_w[g]),
            .base_i (base_w),
            .phys_o (phys_w[g])
        );
    end

    rrf_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) store_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (wr_en_i),
        .wr_phys_i   (phys_w[0]),
        .wr_data_i   (wr_data_i),
        .rd_a_phys_i (phys_w[1]),
        .rd_a_data_o (rd_a_data_o),
        .rd_b_phys_i (phys_w[2]),
        .rd_b_data_o (rd_b_data_o)
    );

    assert_rd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx_i == '0) |-> (rd_a_data_o == '0));
    assert_static_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idx_i < IDX_W'(NUM_STATIC)) |-> (phys_w[0] == wr_idx_i));
    assert_region_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_idx_i >= IDX_W'(NUM_STATIC)) |-> (phys_w[2] >= IDX_W'(NUM_STATIC)));
endmodule

// File: tb/rrf_rotating_regfile_tb.sv
`timescale 1ns/1ps
module rrf_rotating_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rot = 1'b0, clr = 1'b0, we = 1'b0;
    logic [6:0]  widx = '0, ra = '0, rb = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rda, rdb;
    int          n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    rrf_rotating_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .rot_i(rot), .clr_i(clr),
        .wr_en_i(we), .wr_idx_i(widx), .wr_data_i(wdata),
        .rd_a_idx_i(ra), .rd_a_data_o(rda),
        .rd_b_idx_i(rb), .rd_b_data_o(rdb)
    );

    typedef struct packed {
        logic        rot, clr, we;
        logic [6:0]  widx;
        logic [63:0] wdata;
        logic [6:0]  ra, rb;
        logic [63:0] ea, eb;
        logic [3:0]  req;
    } vec_t;

    // Reads in a row see the state before that row's clock edge.
    localparam vec_t TBL [10] = '{
        '{1'b0,1'b0,1'b1, 7'd5,  64'h11, 7'd5,  7'd0,   64'h0,  64'h0,  4'd12}, // R12 old value on same-cycle read
        '{1'b0,1'b0,1'b1, 7'd40, 64'h22, 7'd5,  7'd0,   64'h11, 64'h0,  4'd3},  // R3
        '{1'b0,1'b0,1'b1, 7'd0,  64'hFF, 7'd40, 7'd0,   64'h22, 64'h0,  4'd4},  // R4
        '{1'b1,1'b0,1'b1, 7'd127,64'h33, 7'd0,  7'd127, 64'h0,  64'h0,  4'd2},  // R2 write to 0 ignored; R7 write+rotate
        '{1'b0,1'b0,1'b1, 7'd50, 64'h44, 7'd32, 7'd41,  64'h33, 64'h22, 4'd6},  // R6 wrap, R7 old base, R5
        '{1'b1,1'b0,1'b0, 7'd0,  64'h0,  7'd50, 7'd5,   64'h44, 64'h11, 4'd11}, // R11 independent ports, R3
        '{1'b0,1'b0,1'b0, 7'd0,  64'h0,  7'd51, 7'd42,  64'h44, 64'h22, 4'd5},  // R5
        '{1'b1,1'b1,1'b0, 7'd0,  64'h0,  7'd40, 7'd33,  64'h0,  64'h33, 4'd9},  // R9 base still 94 here
        '{1'b0,1'b0,1'b0, 7'd0,  64'h0,  7'd40, 7'd127, 64'h22, 64'h33, 4'd8},  // R8 identity after clear
        '{1'b0,1'b0,1'b0, 7'd0,  64'h0,  7'd49, 7'd5,   64'h44, 64'h11, 4'd9}   // R9 clear won
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_cycles(3);
        @(negedge clk);
        ra = 7'd40; rb = 7'd127;
        #1;
        chk("R1 reset A", rda, 64'h0);
        chk("R1 reset B", rdb, 64'h0);
        rst_n = 1'b1;

        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            rot = TBL[k].rot; clr = TBL[k].clr; we = TBL[k].we;
            widx = TBL[k].widx; wdata = TBL[k].wdata;
            ra = TBL[k].ra; rb = TBL[k].rb;
            #1;
            chk($sformatf("R%0d row %0d port A", TBL[k].req, k), rda, TBL[k].ea);
            chk($sformatf("R%0d row %0d port B", TBL[k].req, k), rdb, TBL[k].eb);
        end
        @(negedge clk);
        rot = 1'b0; clr = 1'b0; we = 1'b0;

        // R10: 95 rotations give base 1, one more returns it to 0
        for (int i = 0; i < 95; i++) begin
            @(negedge clk); rot = 1'b1;
        end
        @(negedge clk); rot = 1'b0;
        ra = 7'd39; rb = 7'd126;
        #1;
        chk("R10 base 1 port A", rda, 64'h22);
        chk("R10 base 1 port B", rdb, 64'h33);
        @(negedge clk); rot = 1'b1;
        @(negedge clk); rot = 1'b0;
        ra = 7'd40; rb = 7'd127;
        #1;
        chk("R10 full turn port A", rda, 64'h22);
        chk("R10 full turn port B", rdb, 64'h33);
        idle_cycles(3);
        @(negedge clk); #1;
        chk("R10 hold", rda, 64'h22);

        // R11: both ports name the same register
        @(negedge clk); ra = 7'd49; rb = 7'd49; #1;
        chk("R11 same reg A", rda, 64'h44);
        chk("R11 same reg B", rdb, 64'h44);

        // R2: write specifier 0 again, read on both ports
        @(negedge clk); we = 1'b1; widx = 7'd0; wdata = 64'hDEAD;
        @(negedge clk); we = 1'b0; ra = 7'd0; rb = 7'd0; #1;
        chk("R2 zero A", rda, 64'h0);
        chk("R2 zero B", rdb, 64'h0);

        // R12: write visible the cycle after its edge
        @(negedge clk); we = 1'b1; widx = 7'd7; wdata = 64'h77; ra = 7'd7; #1;
        chk("R12 before edge", rda, 64'h0);
        @(negedge clk); we = 1'b0; #1;
        chk("R12 after edge", rda, 64'h77);

        // R1: reset mid-run clears contents and base
        @(negedge clk); rot = 1'b1;
        @(negedge clk); rot = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; ra = 7'd7; rb = 7'd40; #1;
        chk("R1 rerun A", rda, 64'h0);
        chk("R1 rerun B", rdb, 64'h0);
        @(negedge clk); we = 1'b1; widx = 7'd64; wdata = 64'h64;
        @(negedge clk); we = 1'b0; ra = 7'd64; #1;
        chk("R1 base zero after reset", rda, 64'h64);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule